// File: doc/BRIEF.md
# Dual-mode compressed instruction expander

The expander sits between instruction fetch and decode in a core that mixes 32-bit normal instructions with 16-bit reduced instructions. It tracks which mode is active. In normal mode each fetched word passes through unchanged. In reduced mode each word holds two halfwords. The lower halfword is handled first and the upper one second. Each halfword becomes exactly one 32-bit normal instruction through a computed lookup table, so decode and execute only ever see normal instructions.

The mode changes at single-instruction granularity. A normal exchange word enters reduced mode, and a reduced exchange halfword returns to normal mode. The reduced set also has four special halfwords:

- A nop, which pads code so that normal code resumes on a word boundary.
- An extend prefix, which widens the immediate of the halfword after it.
- A move, which has wide register fields that reach all 16 registers.
- The exchange halfword described above.

The block emits at most one instruction per cycle. `pc_inc_o` tells fetch that the current word has been fully consumed. Inputs are sampled at the clock edge, and the instruction, valid and error outputs are registered, one cycle after the input is accepted.

Top module: `cx_expander`

## Requirements
- R1: While `rst_ni` is low, `instr_valid_o`, `illegal_o`, `align_err_o`, `reduced_mode_o` and `instr_o` are all zero, and no extend prefix is pending.
- R2: In normal mode, a presented word whose top byte [31:24] is not 8'hFE is consumed in one cycle (`pc_inc_o` high in that cycle). The word appears unchanged on `instr_o`, with `instr_valid_o` high, in the next cycle.
- R3: In normal mode, a word with [31:24] = 8'hFE is consumed in one cycle and emits no instruction. From the next cycle on, `reduced_mode_o` is high.
- R4: A reduced halfword has opcode [15:9], rd [8:6], rs1 [5:3] and field f [2:0]. An opcode below TABLE_DEPTH (default 8) expands to {OP_BASE+op, 0,rd, 0,rs1, 0,f, 9'b0,f}, with OP_BASE defaulting to 8'h10. The lower halfword is expanded first and the upper second. `pc_inc_o` is high only in the cycle that consumes the upper halfword.
- R5: Opcode 7'h7D is an extend prefix carrying bits [8:0]. It emits nothing. The next table instruction uses those 9 bits in place of the 9 zero bits at [11:3] of its immediate.
- R6: An extend prefix that directly follows an extend prefix raises `illegal_o` for one cycle with `instr_valid_o` low. It leaves no prefix pending, so a later table instruction has zero upper immediate bits.
- R7: Opcode 7'h7C is a move with a 4-bit destination [7:4] and a 4-bit source [3:0]. It expands to {8'h01, dst, src, 16'h0000}.
- R8: Opcode 7'h7E is a nop. It emits nothing, sets no flag and consumes a halfword slot.
- R9: Opcode 7'h7F returns the block to normal mode and emits nothing.
  - In the lower halfword, it consumes the whole word in one cycle.
  - In the lower halfword with an upper halfword that is not a nop, it also raises `align_err_o` for one cycle.
  - Any pending extend prefix is cleared by the mode change.
- R10: Any other reduced opcode (not in the table and not 7'h7C to 7'h7F) raises `illegal_o` for one cycle with `instr_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | A fetched word is presented |
| fetch_word_i | input | 32 | Fetched word, held until consumed |
| instr_o | output | 32 | Expanded normal instruction |
| instr_valid_o | output | 1 | `instr_o` carries a new instruction this cycle |
| illegal_o | output | 1 | Illegal reduced instruction seen |
| align_err_o | output | 1 | Lower-half exchange not padded with a nop |
| reduced_mode_o | output | 1 | Reduced mode is active |
| pc_inc_o | output | 1 | Current word fully consumed; fetch may advance |

## Verification
The hardest situations to reach are the ones that depend on the prefix and mode state left behind by earlier halfwords:

- a double extend that must drop the pending prefix;
- an extend followed directly by an exchange, which must leave nothing pending in normal mode;
- a lower-half exchange with a bad upper half.

The stimulus therefore builds words whose two halves chain these cases. Each case is followed by a table instruction or a normal word whose expected encoding shows whether stale prefix or mode state leaked through. The scoreboard also counts the cycles taken for each word, so a wrong consumption point is caught even when the emitted instructions are correct.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam logic [7:0] XCHG_N = 8'hFE;
  localparam logic [7:0] MOV_N  = 8'h01;
  localparam logic [6:0] R_XCHG = 7'h7F;
  localparam logic [6:0] R_NOP  = 7'h7E;
  localparam logic [6:0] R_EXT  = 7'h7D;
  localparam logic [6:0] R_MOV  = 7'h7C;
  localparam int unsigned EXT_W = 9;

  typedef struct packed {
    logic             valid;
    logic             illegal;
    logic             ext_load;
    logic             xchg;
    logic [EXT_W-1:0] ext_bits;
    logic [31:0]      instr;
  } exp_res_t;
endpackage

// File: rtl/cx_lut.sv
module cx_lut #(
  parameter int unsigned TABLE_DEPTH = 8,
  parameter logic [7:0]  OP_BASE     = 8'h10
) (
  input  logic [6:0] op_i,
  output logic       hit_o,
  output logic [7:0] norm_op_o
);
  localparam int unsigned IDX_W = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;

  logic [7:0] table_q [TABLE_DEPTH];

  for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_ent
    assign table_q[i] = OP_BASE + 8'(i);
  end

  logic [IDX_W-1:0] idx;
  assign idx       = IDX_W'(op_i);
  assign hit_o     = ({25'd0, op_i} < TABLE_DEPTH);
  assign norm_op_o = hit_o ? table_q[idx] : 8'h00;
endmodule

// File: rtl/cx_half_expand.sv
module cx_half_expand
  import cx_pkg::*;
#(
  parameter int unsigned TABLE_DEPTH = 8,
  parameter logic [7:0]  OP_BASE     = 8'h10
) (
  input  logic [15:0]      half_i,
  input  logic             ext_pend_i,
  input  logic [EXT_W-1:0] ext_bits_i,
  output exp_res_t         res_o
);
  logic [6:0] op;
  logic       hit;
  logic [7:0] norm_op;

  assign op = half_i[15:9];

  cx_lut #(.TABLE_DEPTH(TABLE_DEPTH), .OP_BASE(OP_BASE)) u_lut (
    .op_i     (op),
    .hit_o    (hit),
    .norm_op_o(norm_op)
  );

  always_comb begin
    res_o = '0;
    if (op == R_EXT) begin
      if (ext_pend_i) res_o.illegal = 1'b1;
      else begin
        res_o.ext_load = 1'b1;
        res_o.ext_bits = half_i[8:0];
      end
    end else if (op == R_XCHG) begin
      res_o.xchg = 1'b1;
    end else if (op == R_NOP) begin
      res_o.valid = 1'b0;
    end else if (op == R_MOV) begin
      res_o.valid = 1'b1;
      res_o.instr = {MOV_N, half_i[7:4], half_i[3:0], 16'h0000};
    end else if (hit) begin
      res_o.valid = 1'b1;
      res_o.instr = {norm_op, 1'b0, half_i[8:6], 1'b0, half_i[5:3], 1'b0, half_i[2:0],
                     (ext_pend_i ? ext_bits_i : {EXT_W{1'b0}}), half_i[2:0]};
    end else begin
      res_o.illegal = 1'b1;
    end
  end
endmodule

// File: rtl/cx_seq.sv
module cx_seq
  import cx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic [31:0]      fetch_word_i,
  input  exp_res_t         res_i,
  output logic             mode_o,
  output logic             half_o,
  output logic             ext_pend_o,
  output logic [EXT_W-1:0] ext_bits_o,
  output logic             done_o,
  output logic [31:0]      instr_o,
  output logic             valid_o,
  output logic             illegal_o,
  output logic             align_err_o
);
  logic             mode_q, mode_d;
  logic             half_q, half_d;
  logic             pend_q, pend_d;
  logic [EXT_W-1:0] bits_q, bits_d;
  logic             emit_v, emit_ill, emit_al;
  logic [31:0]      emit_i;

  always_comb begin
    mode_d   = mode_q;
    half_d   = half_q;
    pend_d   = pend_q;
    bits_d   = bits_q;
    done_o   = 1'b0;
    emit_v   = 1'b0;
    emit_ill = 1'b0;
    emit_al  = 1'b0;
    emit_i   = fetch_word_i;
    if (fetch_valid_i) begin
      if (!mode_q) begin
        done_o = 1'b1;
        if (fetch_word_i[31:24] == XCHG_N) begin
          mode_d = 1'b1;
          half_d = 1'b0;
        end else begin
          emit_v = 1'b1;
        end
      end else if (res_i.xchg) begin
        // lower-half exchange consumes the whole word; upper must be padding
        done_o  = 1'b1;
        mode_d  = 1'b0;
        half_d  = 1'b0;
        pend_d  = 1'b0;
        emit_al = !half_q && (fetch_word_i[31:25] != R_NOP);
      end else begin
        done_o   = half_q;
        half_d   = ~half_q;
        emit_v   = res_i.valid;
        emit_ill = res_i.illegal;
        emit_i   = res_i.instr;
        pend_d   = res_i.ext_load;
        if (res_i.ext_load) bits_d = res_i.ext_bits;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      half_q      <= 1'b0;
      pend_q      <= 1'b0;
      bits_q      <= '0;
      valid_o     <= 1'b0;
      illegal_o   <= 1'b0;
      align_err_o <= 1'b0;
      instr_o     <= '0;
    end else begin
      mode_q      <= mode_d;
      half_q      <= half_d;
      pend_q      <= pend_d;
      bits_q      <= bits_d;
      valid_o     <= emit_v;
      illegal_o   <= emit_ill;
      align_err_o <= emit_al;
      if (emit_v) instr_o <= emit_i;
    end
  end

  assign mode_o     = mode_q;
  assign half_o     = half_q;
  assign ext_pend_o = pend_q;
  assign ext_bits_o = bits_q;
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int unsigned TABLE_DEPTH = 8,
  parameter logic [7:0]  OP_BASE     = 8'h10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fetch_valid_i,
  input  logic [31:0] fetch_word_i,
  output logic [31:0] instr_o,
  output logic        instr_valid_o,
  output logic        illegal_o,
  output logic        align_err_o,
  output logic        reduced_mode_o,
  output logic        pc_inc_o
);
  logic             half_q;
  logic             ext_pend_q;
  logic [EXT_W-1:0] ext_bits_q;
  logic [15:0]      cur_half;
  exp_res_t         res;

  assign cur_half = half_q ? fetch_word_i[31:16] : fetch_word_i[15:0];

  cx_half_expand #(.TABLE_DEPTH(TABLE_DEPTH), .OP_BASE(OP_BASE)) u_exp (
    .half_i    (cur_half),
    .ext_pend_i(ext_pend_q),
    .ext_bits_i(ext_bits_q),
    .res_o     (res)
  );

  cx_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_valid_i(fetch_valid_i),
    .fetch_word_i (fetch_word_i),
    .res_i        (res),
    .mode_o       (reduced_mode_o),
    .half_o       (half_q),
    .ext_pend_o   (ext_pend_q),
    .ext_bits_o   (ext_bits_q),
    .done_o       (pc_inc_o),
    .instr_o      (instr_o),
    .valid_o      (instr_valid_o),
    .illegal_o    (illegal_o),
    .align_err_o  (align_err_o)
  );
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_valid_i,
  input logic [31:0] fetch_word_i,
  input logic        instr_valid_o,
  input logic        illegal_o,
  input logic        reduced_mode_o,
  input logic        pc_inc_o,
  input logic        half_sel,
  input logic        ext_pend
);
  logic [6:0] cur_op;
  assign cur_op = half_sel ? fetch_word_i[31:25] : fetch_word_i[15:9];

  a_r10_valid_illegal_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_valid_o && illegal_o));

  a_r2_normal_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && !reduced_mode_o |-> pc_inc_o);

  a_r4_lower_holds_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && reduced_mode_o && !half_sel && fetch_word_i[15:9] != 7'h7F |-> !pc_inc_o);

  a_r3_enter_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && !reduced_mode_o && fetch_word_i[31:24] == 8'hFE
    |=> reduced_mode_o && !instr_valid_o);

  a_r9_exit_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && reduced_mode_o && cur_op == 7'h7F |-> pc_inc_o ##1 (!reduced_mode_o && !half_sel));

  a_r9_prefix_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reduced_mode_o) |-> !ext_pend);

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> !instr_valid_o && !reduced_mode_o && !ext_pend);
endmodule

bind cx_expander cx_expander_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_word_i  (fetch_word_i),
  .instr_valid_o (instr_valid_o),
  .illegal_o     (illegal_o),
  .reduced_mode_o(reduced_mode_o),
  .pc_inc_o      (pc_inc_o),
  .half_sel      (half_q),
  .ext_pend      (ext_pend_q)
);

// File: tb/cx_expander_tb_top.sv
module cx_expander_tb_top;
  localparam logic [7:0] OP_BASE = 8'h10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_word_i = '0;
  logic [31:0] instr_o;
  logic        instr_valid_o, illegal_o, align_err_o, reduced_mode_o, pc_inc_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  cx_expander dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i), .fetch_word_i(fetch_word_i),
    .instr_o(instr_o), .instr_valid_o(instr_valid_o), .illegal_o(illegal_o),
    .align_err_o(align_err_o), .reduced_mode_o(reduced_mode_o), .pc_inc_o(pc_inc_o)
  );

  // kind: 0 instruction, 1 illegal, 2 alignment error
  typedef struct packed { logic [1:0] k; logic [31:0] d; } exp_t;
  exp_t  exp_q[$];
  string req_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic expect_item(input logic [1:0] k, input logic [31:0] d, input string req);
    exp_q.push_back({k, d});
    req_q.push_back(req);
  endtask

  function automatic logic [15:0] rh(input logic [6:0] op, input logic [2:0] a, input logic [2:0] b, input logic [2:0] f);
    return {op, a, b, f};
  endfunction
  function automatic logic [31:0] tbl(input logic [6:0] op, input logic [2:0] a, input logic [2:0] b,
                                      input logic [2:0] f, input logic [8:0] ext);
    return {OP_BASE + {1'b0, op}, 1'b0, a, 1'b0, b, 1'b0, f, ext, f};
  endfunction

  // monitor: compares each emitted event with the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && !done_run) begin
      if (instr_valid_o || illegal_o || align_err_o) begin
        logic [1:0] k;
        k = instr_valid_o ? 2'd0 : (illegal_o ? 2'd1 : 2'd2);
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected output", {30'd0, k}, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (k == 2'd0) check(e.k == 2'd0 && instr_o == e.d, r, instr_o, e.d);
          else check(e.k == k, r, {30'd0, k}, {30'd0, e.k});
        end
      end
    end
  end

  task automatic drive_word(input logic [31:0] w, input int ncyc, input string req);
    int n = 0;
    bit d;
    fetch_valid_i = 1'b1;
    fetch_word_i  = w;
    do begin
      #1;
      d = pc_inc_o;
      n++;
      @(negedge clk);
    end while (!d && n < 10);
    check(n == ncyc, {req, " consume cycles"}, n, ncyc);
  endtask

  task automatic idle(input int n);
    fetch_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({instr_valid_o, illegal_o, align_err_o, reduced_mode_o} == 4'b0 && instr_o == 32'h0,
          "R1 reset outputs", {28'd0, instr_valid_o, illegal_o, align_err_o, reduced_mode_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 pass-through
    expect_item(0, 32'h1234_5678, "R2 passthrough a");
    drive_word(32'h1234_5678, 1, "R2");
    expect_item(0, 32'hA000_0001, "R2 passthrough b");
    drive_word(32'hA000_0001, 1, "R2");
    idle(2);

    // R3 enter reduced
    drive_word(32'hFE00_0000, 1, "R3");
    idle(1);
    check(reduced_mode_o == 1'b1, "R3 mode after exchange", reduced_mode_o, 1);

    // R4 two table halves, lower first
    expect_item(0, tbl(7'd0, 3'd1, 3'd2, 3'd3, 9'd0), "R4 lower half");
    expect_item(0, tbl(7'd5, 3'd7, 3'd6, 3'd7, 9'd0), "R4 upper half");
    drive_word({rh(7'd5, 3'd7, 3'd6, 3'd7), rh(7'd0, 3'd1, 3'd2, 3'd3)}, 2, "R4");

    // R5 extend then table op
    expect_item(0, tbl(7'd2, 3'd1, 3'd3, 3'd5, 9'h1A5), "R5 extended immediate");
    drive_word({rh(7'd2, 3'd1, 3'd3, 3'd5), 7'h7D, 9'h1A5}, 2, "R5");

    // R6 double extend, then pending must be gone; R7 move in upper
    expect_item(1, 0, "R6 double extend illegal");
    drive_word({7'h7D, 9'h0FF, 7'h7D, 9'h155}, 2, "R6");
    expect_item(0, tbl(7'd1, 3'd4, 3'd5, 3'd6, 9'd0), "R6 prefix dropped");
    expect_item(0, {8'h01, 4'hB, 4'h9, 16'h0}, "R7 move full regs");
    drive_word({7'h7C, 1'b0, 4'hB, 4'h9, rh(7'd1, 3'd4, 3'd5, 3'd6)}, 2, "R7");

    // R10 unmapped opcode, R8 nop in upper
    expect_item(1, 0, "R10 unmapped opcode");
    drive_word({7'h7E, 9'h0, rh(7'h40, 3'd1, 3'd1, 3'd1)}, 2, "R8 R10");
    idle(2);
    check(exp_q.size() == 0, "R8 nop emits nothing", exp_q.size(), 0);

    // R9 extend then exchange in upper: back to normal, prefix cleared
    drive_word({7'h7F, 9'h0, 7'h7D, 9'h1FF}, 2, "R9 upper exchange");
    idle(1);
    check(reduced_mode_o == 1'b0, "R9 mode after upper exchange", reduced_mode_o, 0);
    expect_item(0, 32'h5555_0000, "R9 normal after exit");
    drive_word(32'h5555_0000, 1, "R9");

    // R9 lower exchange with nop padding: one cycle, no error
    drive_word(32'hFE00_0000, 1, "R3");
    drive_word({7'h7E, 9'h0, 7'h7F, 9'h0}, 1, "R9 padded");
    idle(1);
    check(reduced_mode_o == 1'b0, "R9 padded exit mode", reduced_mode_o, 0);
    // prefix must not survive: re-enter and expand a table op
    drive_word(32'hFE00_0000, 1, "R3");
    expect_item(0, tbl(7'd3, 3'd2, 3'd2, 3'd2, 9'd0), "R9 no stale prefix");
    expect_item(0, tbl(7'd7, 3'd0, 3'd1, 3'd0, 9'd0), "R4 top table entry");
    drive_word({rh(7'd7, 3'd0, 3'd1, 3'd0), rh(7'd3, 3'd2, 3'd2, 3'd2)}, 2, "R4");

    // R10 first opcode past table
    expect_item(1, 0, "R10 opcode past table");
    drive_word({7'h7E, 9'h0, rh(7'd8, 3'd0, 3'd0, 3'd0)}, 2, "R10");

    // R9 lower exchange without padding: alignment error
    expect_item(2, 0, "R9 align error");
    drive_word({rh(7'd1, 3'd1, 3'd1, 3'd1), 7'h7F, 9'h0}, 1, "R9 unpadded");
    idle(2);
    check(reduced_mode_o == 1'b0, "R9 unpadded exit mode", reduced_mode_o, 0);
    expect_item(0, 32'h0BAD_F00D, "R2 after error");
    drive_word(32'h0BAD_F00D, 1, "R2");
    idle(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    done_run = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule